// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns a virtual effective address into its final page table entry. It walks a tree of directories held in memory, starting from a root base address and a root index size. Each level costs one 64-bit memory read. Software or a translation front end pulses `start` with the root description, the total translated size and the address. The walker then issues one read per level on a simple request/response port. It stops when it reaches a leaf entry, or when the walk has to be abandoned.

Directory bases are expected to be aligned to the size of their directory. A directory of 2^n entries must sit on a 2^(n+3)-byte boundary. When a base breaks this rule, the walker drops the offending low bits before it adds the index offset, so it accesses the same address that real hardware would. It also raises a sticky flag so that the misconfiguration is visible even when the walk succeeds.

Top module: `radix_walker`

## Requirements
- R1: While `rst` is high and after it falls, `busy`, `done`, `mem_req`, `fault` and `misalign` are low until the first accepted `start`.
- R2: For each level the read address is (base with bits [n+2:0] cleared) + 8 × index. The index is (eaddr >> (remaining − n)) masked to n bits, and n is the current index size. There is one single-cycle `mem_req` pulse per level, and no new request is issued until `mem_rvalid` answers the previous one.
- R3: The remaining size drops by the current index size at every level, and `leaf_size` reports the remaining size after the leaf's level.
- R4: The entry encoding is as follows: bit 63 is valid, bit 62 is leaf, bits [55:8] form the next base (its bits [7:0] are zero), and bits [4:0] give the next index size. A valid non-leaf entry starts the next level with these fields.
- R5: `misalign` is set when the root base or any next-level base has a nonzero bit in [n+2:0]. It stays set to the end of the walk and is cleared only by the next accepted `start`.
- R6: A fetched entry with bit 63 clear ends the walk with `fault` high and `leaf_entry` zero.
- R7: If MAX_LEVELS (default 4) entries have been fetched without reaching a leaf, the walk ends with `fault`.
- R8: An index size larger than the remaining size ends the walk with `fault` and issues no read for that level.
- R9: `start` is ignored while `busy` is high, and the walk in progress completes with its original inputs.
- R10: `busy` rises in the cycle after an accepted `start` and falls together with a single-cycle `done`. `fault`, `leaf_entry`, `leaf_size` and `misalign` hold until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (taken when idle) |
| root_base | input | PA_W | Root directory base address |
| root_nls | input | 5 | Root index size in bits |
| total_size | input | SIZE_W | Number of address bits translated by the tree |
| eaddr | input | VA_W | Effective address to translate |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| fault | output | 1 | Walk ended without a leaf |
| misalign | output | 1 | Sticky misaligned-base flag |
| leaf_entry | output | 64 | Leaf entry found by the walk |
| leaf_size | output | SIZE_W | Remaining size at the leaf (log2 page size) |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | PA_W | Read address of the entry |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |

## Verification
A wrong base, index size or remaining size inside the walker shows up on `mem_addr` at the very next request. The bench compares every request against an address list produced by its own model, so such an error is reported within one level of its cause. Masking errors are made visible because the test tables live only at the masked addresses: an unmasked or added-in misalignment reads empty memory and turns into a fault at `done`. A wrong level count or a lost sticky flag shows up at the `done` pulse of the walk in which it happens.

// File: rtl/rpw_pkg.sv
package rpw_pkg;
  localparam int ENT_W     = 64;
  localparam int NLS_W     = 5;
  localparam int VALID_BIT = 63;
  localparam int LEAF_BIT  = 62;
  localparam int NLB_HI    = 55;
  localparam int NLB_LO    = 8;
  localparam int ENT_SHIFT = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WAIT
  } walk_state_e;
endpackage

// File: rtl/rpw_addr_gen.sv
module rpw_addr_gen
  import rpw_pkg::*;
#(
  parameter int PA_W   = 56,
  parameter int VA_W   = 64,
  parameter int SIZE_W = 7
) (
  input  logic [PA_W-1:0]   base,
  input  logic [NLS_W-1:0]  nls,
  input  logic [SIZE_W-1:0] rsize,
  input  logic [VA_W-1:0]   eaddr,
  output logic [PA_W-1:0]   ent_addr,
  output logic              misaligned,
  output logic              too_big,
  output logic [SIZE_W-1:0] next_rsize
);
  logic [PA_W-1:0] align_mask;
  logic [VA_W-1:0] idx_mask;
  logic [VA_W-1:0] idx;
  logic [5:0]      align_bits;

  always_comb begin
    align_bits = {1'b0, nls} + 6'd3;
    align_mask = (PA_W'(1) << align_bits) - PA_W'(1);
    too_big    = SIZE_W'(nls) > rsize;
    next_rsize = rsize - SIZE_W'(nls);
    idx_mask   = (VA_W'(1) << nls) - VA_W'(1);
    idx        = (eaddr >> next_rsize) & idx_mask;
    misaligned = |(base & align_mask);
    ent_addr   = (base & ~align_mask) + (PA_W'(idx) << ENT_SHIFT);
  end
endmodule

// File: rtl/rpw_entry_decode.sv
module rpw_entry_decode
  import rpw_pkg::*;
#(
  parameter int PA_W = 56
) (
  input  logic [ENT_W-1:0] entry,
  output logic             valid,
  output logic             leaf,
  output logic [PA_W-1:0]  nlb,
  output logic [NLS_W-1:0] nls
);
  always_comb begin
    valid = entry[VALID_BIT];
    leaf  = entry[LEAF_BIT];
    nlb   = PA_W'({entry[NLB_HI:NLB_LO], {NLB_LO{1'b0}}});
    nls   = entry[NLS_W-1:0];
  end
endmodule

// File: rtl/radix_walker.sv
module radix_walker
  import rpw_pkg::*;
#(
  parameter int PA_W       = 56,
  parameter int VA_W       = 64,
  parameter int SIZE_W     = 7,
  parameter int MAX_LEVELS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [PA_W-1:0]   root_base,
  input  logic [4:0]        root_nls,
  input  logic [SIZE_W-1:0] total_size,
  input  logic [VA_W-1:0]   eaddr,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic              misalign,
  output logic [63:0]       leaf_entry,
  output logic [SIZE_W-1:0] leaf_size,
  output logic              mem_req,
  output logic [PA_W-1:0]   mem_addr,
  input  logic              mem_rvalid,
  input  logic [63:0]       mem_rdata
);
  localparam int LVL_W = (MAX_LEVELS > 2) ? $clog2(MAX_LEVELS) : 1;
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(MAX_LEVELS - 1);

  walk_state_e       state;
  logic [PA_W-1:0]   base_q;
  logic [NLS_W-1:0]  nls_q;
  logic [SIZE_W-1:0] rsize_q;
  logic [VA_W-1:0]   ea_q;
  logic [LVL_W-1:0]  level_q;

  logic [PA_W-1:0]   ag_addr;
  logic              ag_misaligned;
  logic              ag_too_big;
  logic [SIZE_W-1:0] ag_next_rsize;

  logic              dec_valid;
  logic              dec_leaf;
  logic [PA_W-1:0]   dec_nlb;
  logic [NLS_W-1:0]  dec_nls;

  rpw_addr_gen #(.PA_W(PA_W), .VA_W(VA_W), .SIZE_W(SIZE_W)) u_agen (
    .base       (base_q),
    .nls        (nls_q),
    .rsize      (rsize_q),
    .eaddr      (ea_q),
    .ent_addr   (ag_addr),
    .misaligned (ag_misaligned),
    .too_big    (ag_too_big),
    .next_rsize (ag_next_rsize)
  );

  rpw_entry_decode #(.PA_W(PA_W)) u_dec (
    .entry (mem_rdata),
    .valid (dec_valid),
    .leaf  (dec_leaf),
    .nlb   (dec_nlb),
    .nls   (dec_nls)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      base_q     <= '0;
      nls_q      <= '0;
      rsize_q    <= '0;
      ea_q       <= '0;
      level_q    <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      fault      <= 1'b0;
      misalign   <= 1'b0;
      leaf_entry <= '0;
      leaf_size  <= '0;
      mem_req    <= 1'b0;
      mem_addr   <= '0;
    end else begin
      done    <= 1'b0;
      mem_req <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            ea_q       <= eaddr;
            base_q     <= root_base;
            nls_q      <= root_nls;
            rsize_q    <= total_size;
            level_q    <= '0;
            misalign   <= 1'b0;
            fault      <= 1'b0;
            leaf_entry <= '0;
            leaf_size  <= '0;
            busy       <= 1'b1;
            state      <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          if (ag_too_big) begin
            fault <= 1'b1;
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else begin
            if (ag_misaligned) misalign <= 1'b1;
            mem_addr <= ag_addr;
            mem_req  <= 1'b1;
            rsize_q  <= ag_next_rsize;
            state    <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (mem_rvalid) begin
            if (!dec_valid || (!dec_leaf && level_q == LAST_LVL)) begin
              fault <= 1'b1;
              done  <= 1'b1;
              busy  <= 1'b0;
              state <= ST_IDLE;
            end else if (dec_leaf) begin
              leaf_entry <= mem_rdata;
              leaf_size  <= rsize_q;
              done       <= 1'b1;
              busy       <= 1'b0;
              state      <= ST_IDLE;
            end else begin
              base_q  <= dec_nlb;
              nls_q   <= dec_nls;
              level_q <= level_q + LVL_W'(1);
              state   <= ST_ADDR;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rpw_checker.sv
module rpw_checker #(
  parameter int PA_W = 56
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            fault,
  input logic            misalign,
  input logic            mem_req,
  input logic [PA_W-1:0] mem_addr
);
  p_single_req_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  p_addr_8b_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[2:0] == 3'b000));

  p_req_busy_r10: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(misalign) && $stable(fault)));

  p_busy_start_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> (busy || done));
endmodule

bind radix_walker rpw_checker #(.PA_W(PA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .fault    (fault),
  .misalign (misalign),
  .mem_req  (mem_req),
  .mem_addr (mem_addr)
);

// File: tb/sim_radix_walker.sv
module sim_radix_walker;
  localparam int PA_W = 56;
  localparam int VA_W = 64;
  localparam int SW   = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [PA_W-1:0] root_base = '0;
  logic [4:0] root_nls = '0;
  logic [SW-1:0] total_size = '0;
  logic [VA_W-1:0] eaddr = '0;
  logic busy, done, fault, misalign, mem_req;
  logic [63:0] leaf_entry;
  logic [SW-1:0] leaf_size;
  logic [PA_W-1:0] mem_addr;
  logic mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;

  always #4 clk = ~clk;

  radix_walker #(.PA_W(PA_W), .VA_W(VA_W), .SIZE_W(SW), .MAX_LEVELS(4)) u0 (
    .clk(clk), .rst(rst), .start(start), .root_base(root_base),
    .root_nls(root_nls), .total_size(total_size), .eaddr(eaddr),
    .busy(busy), .done(done), .fault(fault), .misalign(misalign),
    .leaf_entry(leaf_entry), .leaf_size(leaf_size), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] mem [logic [63:0]];
  logic [63:0] exp_q [$];
  int rsp_cnt = 0;
  logic [63:0] rsp_addr = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(input logic [63:0] a);
    if (mem.exists(a)) return mem[a];
    return 64'h0;
  endfunction

  // address of the slot for one level, per R2
  function automatic logic [63:0] slot(input logic [63:0] b, input int n,
                                       input int rs, input logic [63:0] ea);
    logic [63:0] m;
    logic [63:0] ix;
    m  = (64'd1 << (n + 3)) - 64'd1;
    ix = (ea >> (rs - n)) & ((64'd1 << n) - 64'd1);
    return (b & ~m) + ix * 8;
  endfunction

  function automatic logic [63:0] mk_dir(input logic [63:0] b, input int n);
    return {2'b10, 6'b0, b[55:8], 3'b0, 5'(n)};
  endfunction

  // memory responder: data two cycles after the request is seen
  always @(negedge clk) begin
    if (rsp_cnt == 1) begin
      mem_rvalid = 1'b1;
      mem_rdata  = rd(rsp_addr);
      rsp_cnt    = 0;
    end else begin
      mem_rvalid = 1'b0;
      if (rsp_cnt > 1) rsp_cnt--;
    end
    if (mem_req) begin
      rsp_addr = 64'(mem_addr);
      rsp_cnt  = 2;
    end
  end

  // request comparator, every clock
  always @(negedge clk) begin
    if (!rst && mem_req) begin
      if (exp_q.size() == 0) chk(1'b0, "R2", "unexpected request", 64'(mem_addr), 64'h0);
      else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        chk(64'(mem_addr) == e, "R2", "request address", 64'(mem_addr), e);
      end
    end
  end

  logic        m_fault, m_mis;
  logic [63:0] m_leaf;
  int          m_size;

  task automatic model(input logic [63:0] b, input int n, input int rs,
                       input logic [63:0] ea);
    logic [63:0] a, e, m;
    m_fault = 0; m_mis = 0; m_leaf = 0; m_size = 0;
    for (int lv = 0; lv < 4; lv++) begin
      if (n > rs) begin m_fault = 1; return; end
      m = (64'd1 << (n + 3)) - 64'd1;
      if ((b & m) != 0) m_mis = 1;
      a = slot(b, n, rs, ea);
      exp_q.push_back(a);
      rs = rs - n;
      e = rd(a);
      if (!e[63]) begin m_fault = 1; return; end
      if (e[62]) begin m_leaf = e; m_size = rs; return; end
      if (lv == 3) begin m_fault = 1; return; end
      b = {8'b0, e[55:8], 8'b0};
      n = int'(e[4:0]);
    end
  endtask

  task automatic walk(input string req, input logic [63:0] rb, input int rn,
                      input int sz, input logic [63:0] ea, input bit disturb);
    int t;
    exp_q.delete();
    model(rb, rn, sz, ea);
    @(negedge clk);
    root_base = rb[PA_W-1:0]; root_nls = 5'(rn); total_size = SW'(sz); eaddr = ea;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10", {req, " busy after start"}, 64'(busy), 64'd1);
    if (disturb) begin
      @(negedge clk);
      @(negedge clk);
      root_base = '1; root_nls = 5'd2; total_size = SW'(40); eaddr = '1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (!done && t < 200) begin @(negedge clk); t++; end
    chk(done == 1'b1, "R10", {req, " done seen"}, 64'(done), 64'd1);
    chk(fault == m_fault, req, "fault", 64'(fault), 64'(m_fault));
    chk(misalign == m_mis, "R5", {req, " misalign"}, 64'(misalign), 64'(m_mis));
    chk(leaf_entry == m_leaf, req, "leaf entry", leaf_entry, m_leaf);
    chk(int'(leaf_size) == m_size, "R3", {req, " leaf size"}, 64'(leaf_size), 64'(m_size));
    chk(exp_q.size() == 0, "R2", {req, " all levels fetched"}, 64'(exp_q.size()), 64'd0);
    @(negedge clk);
    chk(!done && !busy, "R10", {req, " done single pulse"}, 64'({busy, done}), 64'd0);
    chk(fault == m_fault && leaf_entry == m_leaf && misalign == m_mis, "R10",
        {req, " results held"}, leaf_entry, m_leaf);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chk(1'b0, "R10", "watchdog expired", 64'd0, 64'd1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] ea1, ea2, ea3, ea5, ea7, a;
    int rs;
    ea1 = 64'h000A_BCDE_F123_4000;
    ea2 = ea1 ^ (64'd1 << 35);
    ea3 = 64'h0003_1415_9265_3000;
    ea5 = 64'h0007_7777_7777_7000;
    ea7 = 64'h0000_0000_2BCD_E000;

    // tree one: aligned, four levels
    rs = 52;
    a = slot(64'h10000, 13, rs, ea1); mem[a] = mk_dir(64'h200000, 9); rs -= 13;
    a = slot(64'h200000, 9, rs, ea1); mem[a] = mk_dir(64'h300000, 9); rs -= 9;
    a = slot(64'h300000, 9, rs, ea1); mem[a] = mk_dir(64'h400000, 9); rs -= 9;
    a = slot(64'h400000, 9, rs, ea1); mem[a] = 64'hC000_0000_1234_5006;
    // tree two: misaligned next-level base
    rs = 52;
    a = slot(64'h800000, 4, rs, ea3); mem[a] = mk_dir(64'h901100, 9); rs -= 4;
    a = slot(64'h901000, 9, rs, ea3); mem[a] = 64'hC000_0000_0ABC_D001;
    // tree three: never reaches a leaf
    rs = 52;
    a = slot(64'hA00000, 5, rs, ea5); mem[a] = mk_dir(64'hB00000, 5); rs -= 5;
    a = slot(64'hB00000, 5, rs, ea5); mem[a] = mk_dir(64'hC00000, 5); rs -= 5;
    a = slot(64'hC00000, 5, rs, ea5); mem[a] = mk_dir(64'hD00000, 5); rs -= 5;
    a = slot(64'hD00000, 5, rs, ea5); mem[a] = mk_dir(64'hE00000, 5);
    // tree four: leaf at the root level
    a = slot(64'hF00000, 10, 30, ea7); mem[a] = 64'hC000_0000_0555_0003;

    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req && !fault && !misalign, "R1", "state in reset",
        64'({busy, done, mem_req, fault, misalign}), 64'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !mem_req && !fault && !misalign, "R1", "state after reset",
        64'({busy, done, mem_req, fault, misalign}), 64'd0);

    walk("R4", 64'h10000, 13, 52, ea1, 1'b0);          // aligned 4-level walk
    walk("R5", 64'h12340, 13, 52, ea1, 1'b0);          // misaligned root base
    chk(misalign == 1'b1, "R5", "root misalign sticky at end", 64'(misalign), 64'd1);
    walk("R9", 64'h10000, 13, 52, ea1, 1'b1);          // clears sticky, start ignored
    walk("R5", 64'h800000, 4, 52, ea3, 1'b0);          // misaligned next-level base
    walk("R6", 64'h10000, 13, 52, ea2, 1'b0);          // invalid entry
    walk("R7", 64'hA00000, 5, 52, ea5, 1'b0);          // depth exceeded
    walk("R8", 64'h10000, 20, 16, ea1, 1'b0);          // index size too big
    walk("R3", 64'hF00000, 10, 30, ea7, 1'b0);         // leaf at root

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule